// File: doc/BRIEF.md
# Policy-Configurable Register Field

This block is a single software-visible register field whose behaviour on bus writes and bus reads is fixed by parameters. One parameter says whether the bus may read it, write it, or both. Another picks one of nine write semantics: bitwise clear, set or toggle where the data bit is one, the same three where the data bit is zero, force-all-zero, force-all-one, or a plain load of the data. A third picks a side effect of a read: clear the field, set it, or nothing. A field can also be declared reserved, in which case it is a constant zero.

The surrounding register file decodes the address and drives the write strobe with its data and the read strobe. Hardware logic can raise any bit at any time through a per-bit set vector, which is how status and interrupt-pending bits are built on top of the write-one-to-clear policy. The current value is always available to the hardware on a dedicated output, and the bus read data is a gated copy of it.

Top module: `fieldTop`

## Requirements
- R1: On a clock edge with `rst` high the field loads the parameter `RESET_VAL` (zero for a reserved field).
- R2: With the write-one-to-clear policy, each `wrData` bit at 1 on a write clears that field bit; a `hwSet` bit high in the same cycle leaves that bit at 1.
- R3: The one-to-set policy ORs `wrData` into the field and the one-to-toggle policy XORs it in.
- R4: The zero-to-clear, zero-to-set and zero-to-toggle policies act on the field bits whose `wrData` bit is 0 (AND with data, OR with inverted data, XOR with inverted data).
- R5: The force-clear and force-set write policies drive every bit to 0 or to 1 on any write, whatever `wrData` holds.
- R6: The modify policy loads `wrData` on a write; with no write, no read side effect and no `hwSet`, the field holds its value.
- R7: A read-only field ignores writes and returns its value on `rdData`.
- R8: A write-only field returns zero on `rdData`, accepts writes, and a read strobe has no side effect on it.
- R9: With a clear-on-read or set-on-read action, `rdData` during the read cycle shows the value before the update, and the field is all zeros or all ones from the next clock edge.
- R10: When a write and a read side effect fall in the same cycle, the write result is computed first and the read side effect is applied over it.
- R11: In a non-reserved field every `hwSet` bit at 1 forces that field bit to 1 at the next edge, after write and read effects are applied.
- R12: A reserved field holds zero on both `fieldVal` and `rdData` and ignores writes, reads and `hwSet`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Bus write strobe for this field |
| wrData | input | WIDTH | Bus write data |
| rdEn | input | 1 | Bus read strobe for this field |
| hwSet | input | WIDTH | Per-bit set request from hardware |
| rdData | output | WIDTH | Bus read data, zero when the field is not readable |
| fieldVal | output | WIDTH | Current field value for hardware |

## Verification
Every cycle the checker confirms the reset load, the constant zero of a reserved field, the zero read data of a write-only field, that a read-only field without side effects is unchanged by writes, the modify load, the one-to-clear update with hardware-set priority, the clear-on-read result and that every hardware set bit lands. The bench's scenarios are what show the remaining write policies, the order of a write and a read effect in the same cycle, that read data carries the pre-update value, and that zero data turns the force policies into no different result, since these need known starting values and the comparison of many field configurations against one stimulus.

// File: rtl/fieldPkg.sv
package fieldPkg;

  typedef enum logic [1:0] {
    ACC_RO = 2'd0,
    ACC_WO = 2'd1,
    ACC_RW = 2'd2
  } accessE;

  typedef enum logic [3:0] {
    WR_ONE_CLR  = 4'd0,
    WR_ONE_SET  = 4'd1,
    WR_ONE_TGL  = 4'd2,
    WR_ZERO_CLR = 4'd3,
    WR_ZERO_SET = 4'd4,
    WR_ZERO_TGL = 4'd5,
    WR_FORCE_CLR = 4'd6,
    WR_FORCE_SET = 4'd7,
    WR_MODIFY   = 4'd8
  } wrPolicyE;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CLR  = 2'd1,
    RD_SET  = 2'd2
  } rdActionE;

  // strobes from control to datapath
  typedef struct packed {
    logic wrApply;
    logic rdClr;
    logic rdSet;
    logic rdGate;
    logic hwApply;
  } fieldStrobeT;

endpackage

// File: rtl/fieldCtl.sv
module fieldCtl
  import fieldPkg::*;
#(
  parameter accessE   ACCESS    = ACC_RW,
  parameter rdActionE RD_ACTION = RD_NONE,
  parameter bit       RESERVED  = 1'b0
) (
  input  logic        wrEn,
  input  logic        rdEn,
  output fieldStrobeT strobes
);

  localparam bit CAN_WRITE = !RESERVED && (ACCESS != ACC_RO);
  localparam bit CAN_READ  = !RESERVED && (ACCESS != ACC_WO);

  always_comb begin
    strobes         = '0;
    strobes.wrApply = CAN_WRITE && wrEn;
    strobes.rdGate  = CAN_READ;
    strobes.rdClr   = CAN_READ && rdEn && (RD_ACTION == RD_CLR);
    strobes.rdSet   = CAN_READ && rdEn && (RD_ACTION == RD_SET);
    strobes.hwApply = !RESERVED;
  end

endmodule

// File: rtl/fieldDp.sv
module fieldDp
  import fieldPkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter wrPolicyE         WR_POLICY = WR_MODIFY,
  parameter logic [WIDTH-1:0] INIT_VAL  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  fieldStrobeT      strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] hwSet,
  output logic [WIDTH-1:0] fieldVal,
  output logic [WIDTH-1:0] rdData
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] curVal;
  logic [WIDTH-1:0] wrResult;
  logic [WIDTH-1:0] afterWrite;
  logic [WIDTH-1:0] afterRead;
  logic [WIDTH-1:0] nextVal;

  // write policy picked at elaboration
  generate
    case (WR_POLICY)
      WR_ONE_CLR:   begin : gOneClr  assign wrResult = curVal & ~wrData; end
      WR_ONE_SET:   begin : gOneSet  assign wrResult = curVal | wrData;  end
      WR_ONE_TGL:   begin : gOneTgl  assign wrResult = curVal ^ wrData;  end
      WR_ZERO_CLR:  begin : gZeroClr assign wrResult = curVal & wrData;  end
      WR_ZERO_SET:  begin : gZeroSet assign wrResult = curVal | ~wrData; end
      WR_ZERO_TGL:  begin : gZeroTgl assign wrResult = curVal ^ ~wrData; end
      WR_FORCE_CLR: begin : gFrcClr  assign wrResult = '0;               end
      WR_FORCE_SET: begin : gFrcSet  assign wrResult = ALL_ONES;         end
      default:      begin : gModify  assign wrResult = wrData;           end
    endcase
  endgenerate

  // order: write, then read side effect, then hardware set
  always_comb begin
    afterWrite = strobes.wrApply ? wrResult : curVal;
    afterRead  = afterWrite;
    if (strobes.rdClr) afterRead = '0;
    if (strobes.rdSet) afterRead = ALL_ONES;
    nextVal = strobes.hwApply ? (afterRead | hwSet) : afterRead;
  end

  always_ff @(posedge clk) begin
    if (rst) curVal <= INIT_VAL;
    else     curVal <= nextVal;
  end

  assign fieldVal = curVal;
  assign rdData   = strobes.rdGate ? curVal : '0;

endmodule

// File: rtl/fieldTop.sv
module fieldTop
  import fieldPkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter accessE           ACCESS    = ACC_RW,
  parameter wrPolicyE         WR_POLICY = WR_MODIFY,
  parameter rdActionE         RD_ACTION = RD_NONE,
  parameter bit               RESERVED  = 1'b0,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic [WIDTH-1:0] hwSet,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] fieldVal
);

  localparam logic [WIDTH-1:0] INIT_VAL = RESERVED ? '0 : RESET_VAL;

  generate
    if (WIDTH < 1) begin : gBadWidth
      $error("field width must be at least one bit");
    end
  endgenerate

  fieldStrobeT strobes;

  fieldCtl #(
    .ACCESS(ACCESS), .RD_ACTION(RD_ACTION), .RESERVED(RESERVED)
  ) uCtl (
    .wrEn(wrEn), .rdEn(rdEn), .strobes(strobes)
  );

  fieldDp #(
    .WIDTH(WIDTH), .WR_POLICY(WR_POLICY), .INIT_VAL(INIT_VAL)
  ) uDp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .hwSet(hwSet), .fieldVal(fieldVal), .rdData(rdData)
  );

endmodule

// File: rtl/fieldChk.sv
module fieldChk
  import fieldPkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter accessE           ACCESS    = ACC_RW,
  parameter wrPolicyE         WR_POLICY = WR_MODIFY,
  parameter rdActionE         RD_ACTION = RD_NONE,
  parameter bit               RESERVED  = 1'b0,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [WIDTH-1:0] wrData,
  input logic             rdEn,
  input logic [WIDTH-1:0] hwSet,
  input logic [WIDTH-1:0] rdData,
  input logic [WIDTH-1:0] fieldVal
);

  localparam logic [WIDTH-1:0] EXP_RESET = RESERVED ? '0 : RESET_VAL;

  a_r1_reset_load: assert property (@(posedge clk)
    $fell(rst) |-> fieldVal == EXP_RESET);

  generate
    if (RESERVED) begin : gRes
      a_r12_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (fieldVal == '0) && (rdData == '0));
    end else begin : gLive
      a_r11_hw_set_lands: assert property (@(posedge clk) disable iff (rst)
        (|hwSet) |=> ((fieldVal & $past(hwSet)) == $past(hwSet)));

      if (ACCESS == ACC_WO) begin : gWo
        a_r8_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
          rdData == '0);
      end

      if (ACCESS == ACC_RO && RD_ACTION == RD_NONE) begin : gRo
        a_r7_ro_ignores_write: assert property (@(posedge clk) disable iff (rst)
          (wrEn && hwSet == '0) |=> $stable(fieldVal));
      end

      if (ACCESS != ACC_RO && WR_POLICY == WR_MODIFY && RD_ACTION == RD_NONE) begin : gMod
        a_r6_modify_loads: assert property (@(posedge clk) disable iff (rst)
          (wrEn && hwSet == '0) |=> fieldVal == $past(wrData));
      end

      if (ACCESS != ACC_RO && WR_POLICY == WR_ONE_CLR && RD_ACTION == RD_NONE) begin : gW1c
        a_r2_one_clear_hw_wins: assert property (@(posedge clk) disable iff (rst)
          wrEn |=> fieldVal == (($past(fieldVal) & ~$past(wrData)) | $past(hwSet)));
      end

      if (ACCESS != ACC_WO && RD_ACTION == RD_CLR) begin : gRdClr
        a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
          (rdEn && hwSet == '0) |=> fieldVal == '0);
      end
    end
  endgenerate

endmodule

bind fieldTop fieldChk #(
  .WIDTH(WIDTH), .ACCESS(ACCESS), .WR_POLICY(WR_POLICY),
  .RD_ACTION(RD_ACTION), .RESERVED(RESERVED), .RESET_VAL(RESET_VAL)
) uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
  .hwSet(hwSet), .rdData(rdData), .fieldVal(fieldVal)
);

// File: tb/sim_fieldTop.sv
module sim_fieldTop;
  import fieldPkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 13;
  localparam logic [W-1:0] RV = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] hwSet = '0;
  logic [W-1:0] fv [N];
  logic [W-1:0] rd [N];

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0: read-write, one-to-clear, used for the status-bit case
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_ONE_CLR), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u0 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[0]), .fieldVal(fv[0]));
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_ONE_SET), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u1 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[1]), .fieldVal(fv[1]));
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_ONE_TGL), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u2 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[2]), .fieldVal(fv[2]));
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_ZERO_CLR), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u3 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[3]), .fieldVal(fv[3]));
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_ZERO_SET), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u4 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[4]), .fieldVal(fv[4]));
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_ZERO_TGL), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u5 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[5]), .fieldVal(fv[5]));
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_FORCE_CLR), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u6 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[6]), .fieldVal(fv[6]));
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_FORCE_SET), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u7 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[7]), .fieldVal(fv[7]));
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_MODIFY), .RD_ACTION(RD_NONE),
    .RESERVED(1'b0), .RESET_VAL(RV)) u8 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[8]), .fieldVal(fv[8]));
  // u9: read-only, clear on read
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RO), .WR_POLICY(WR_MODIFY), .RD_ACTION(RD_CLR),
    .RESERVED(1'b0), .RESET_VAL(RV)) u9 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[9]), .fieldVal(fv[9]));
  // u10: write-only with a read action that must never fire
  fieldTop #(.WIDTH(W), .ACCESS(ACC_WO), .WR_POLICY(WR_MODIFY), .RD_ACTION(RD_CLR),
    .RESERVED(1'b0), .RESET_VAL(RV)) u10 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[10]), .fieldVal(fv[10]));
  // u11: read-write modify, set on read
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_MODIFY), .RD_ACTION(RD_SET),
    .RESERVED(1'b0), .RESET_VAL(RV)) u11 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[11]), .fieldVal(fv[11]));
  // u12: reserved
  fieldTop #(.WIDTH(W), .ACCESS(ACC_RW), .WR_POLICY(WR_MODIFY), .RD_ACTION(RD_SET),
    .RESERVED(1'b1), .RESET_VAL(RV)) u12 (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .hwSet(hwSet), .rdData(rd[12]), .fieldVal(fv[12]));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0; wrData = '0; hwSet = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    chk("R1 u0 reset value", fv[0], RV);
    chk("R1 u8 reset value", fv[8], RV);
    chk("R1 u9 reset value", fv[9], RV);
    chk("R12 u12 reset zero", fv[12], 8'h00);
    chk("R7 u9 read data", rd[9], RV);
    chk("R8 u10 read data zero", rd[10], 8'h00);
  endtask

  task automatic tWriteOnes();
    doReset();
    wrEn = 1'b1; wrData = 8'h3C;
    step();
    wrEn = 1'b0;
    chk("R2 one-to-clear", fv[0], 8'h81);
    chk("R3 one-to-set", fv[1], 8'hBD);
    chk("R3 one-to-toggle", fv[2], 8'h99);
    chk("R4 zero-to-clear", fv[3], 8'h24);
    chk("R4 zero-to-set", fv[4], 8'hE7);
    chk("R4 zero-to-toggle", fv[5], 8'h66);
    chk("R5 force-clear", fv[6], 8'h00);
    chk("R5 force-set", fv[7], 8'hFF);
    chk("R6 modify", fv[8], 8'h3C);
    chk("R7 read-only unchanged", fv[9], RV);
    chk("R8 write-only accepts", fv[10], 8'h3C);
    chk("R8 write-only reads zero", rd[10], 8'h00);
    chk("R12 reserved ignores write", fv[12], 8'h00);
    chk("R12 reserved reads zero", rd[12], 8'h00);
  endtask

  task automatic tWriteZeros();
    doReset();
    wrEn = 1'b1; wrData = 8'h00;
    step();
    wrEn = 1'b0;
    chk("R2 one-to-clear zero data", fv[0], RV);
    chk("R3 one-to-toggle zero data", fv[2], RV);
    chk("R4 zero-to-clear zero data", fv[3], 8'h00);
    chk("R4 zero-to-set zero data", fv[4], 8'hFF);
    chk("R4 zero-to-toggle zero data", fv[5], 8'h5A);
    chk("R5 force-clear zero data", fv[6], 8'h00);
    chk("R5 force-set zero data", fv[7], 8'hFF);
  endtask

  task automatic tHwPriority();
    doReset();
    wrEn = 1'b1; wrData = 8'hFF; hwSet = 8'h0F;
    step();
    wrEn = 1'b0; hwSet = '0;
    chk("R2 hw set beats clear", fv[0], 8'h0F);
    chk("R11 hw set on zero-to-clear", fv[3], 8'hAF);
    chk("R11 hw set on force-clear", fv[6], 8'h0F);
    chk("R11 hw set on read-only", fv[9], 8'hAF);
    chk("R12 reserved ignores hw set", fv[12], 8'h00);
  endtask

  task automatic tReadEffects();
    doReset();
    rdEn = 1'b1;
    #1;
    chk("R9 clear-on-read returns old value", rd[9], RV);
    chk("R9 set-on-read returns old value", rd[11], RV);
    step();
    rdEn = 1'b0;
    chk("R9 clear-on-read updates", fv[9], 8'h00);
    chk("R9 set-on-read updates", fv[11], 8'hFF);
    chk("R8 write-only no read effect", fv[10], RV);
    chk("R12 reserved ignores read", fv[12], 8'h00);
    chk("R6 plain field unchanged by read", fv[0], RV);
  endtask

  task automatic tWriteAndRead();
    doReset();
    wrEn = 1'b1; rdEn = 1'b1; wrData = 8'h3C;
    step();
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R10 set-on-read over write", fv[11], 8'hFF);
    chk("R10 clear-on-read on read-only", fv[9], 8'h00);
    chk("R10 write-only keeps write", fv[10], 8'h3C);
    chk("R6 modify with read", fv[8], 8'h3C);
  endtask

  task automatic tReadHw();
    doReset();
    rdEn = 1'b1; hwSet = 8'h01;
    step();
    rdEn = 1'b0; hwSet = '0;
    chk("R11 hw set after read clear", fv[9], 8'h01);
    chk("R11 hw set after read set", fv[11], 8'hFF);
  endtask

  task automatic tHold();
    doReset();
    step(); step(); step();
    chk("R6 modify holds when idle", fv[8], RV);
    chk("R6 one-to-clear holds when idle", fv[0], RV);
    chk("R6 read-clear field holds when idle", fv[9], RV);
  endtask

  initial begin
    tReset();
    tWriteOnes();
    tWriteZeros();
    tHwPriority();
    tReadEffects();
    tWriteAndRead();
    tReadHw();
    tHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule